// File: doc/BRIEF.md
# Foldback NAND Logic Fabric

This block is a programmable logic fabric made of a single plane of wide NAND gates. Any input of any gate can be connected to any external input, in true or in inverted form, and to the output of any gate in the plane, the gate itself included. Because each gate can feed the others, one cell type builds logic of any depth. A fixed output section turns chosen gates into pins. Some pins have a selectable polarity. Some pins are the XOR of a pair of gates. The bidirectional pins each have a data gate and an output-enable gate.

The fabric is evaluated in clocked passes, so the feedback never forms a combinational loop. A start pulse captures the inputs and clears the gate state. Each following cycle recomputes every gate from the captured literals and the gate values of the pass before. After the programmed number of passes, done is raised. A path that crosses k gates needs at least k passes to settle.

The configuration is one long word, loaded serially while a configuration enable is held high. Gate g owns the ROW_W-bit row at bit offset g*ROW_W. The polarity bits follow the rows. The pass-count field sits at the top.

Top module: `fnand_fabric`

## Requirements
- R1: While cfg_en_i is high, every cycle shifts cfg_d_i into the LSB of the configuration word and moves the older bits toward the MSB. Serial data is therefore sent MSB first. While cfg_en_i is low, the word holds and cfg_d_i has no effect.
- R2: While cfg_en_i is high, start_i is ignored, any running evaluation is abandoned, and done_o reads 0 from the cycle after cfg_en_i was sampled high.
- R3: A start pulse accepted while idle captures ded_i and bid_i. Input changes after that edge have no effect on the result of that evaluation.
- R4: With pass field value n, done_o rises exactly n+1 clock edges after the edge that accepts start. It then stays high until the next accepted start or until cfg_en_i rises.
- R5: A pass count greater than the number of gates is clamped to the number of gates. With 24 gates and n=31, done_o rises after 24 edges.
- R6: The configuration row of gate g uses the following bit positions:
  - Bit 2i connects the true form of input i, and bit 2i+1 connects its complement. Inputs 0..7 are ded_i and inputs 8..11 are bid_i.
  - Bit 24+j connects gate j.
  - The gate state is cleared when start is accepted. Each pass sets every gate to the NAND of its connected literals and the gate values of the previous pass.
  - A gate with nothing connected outputs 0.
- R7: pol_o[k] is gate k XOR polarity bit k, where polarity bit k is configuration bit POL_BASE+k. A single pass with chosen literal polarities therefore gives AND, OR, NAND or NOR.
- R8: xor_o[m] is gate 4+2m XOR gate 5+2m.
- R9: For each bidirectional pin b:
  - bid_o[b] is gate 8+b XOR configuration bit POL_BASE+4+b.
  - bid_oe_o[b] is gate 12+b.
  - The array sees the captured bid_i[b] for that pin's literal when the previous pass left bid_oe_o[b] low, and sees 0 otherwise.
- R10: An output cell whose gate has nothing connected drives its polarity bit alone: 0 when direct, 1 when complemented.
- R11: The same function, programmed once in sum-of-products form on pol_o[0] and once in product-of-sums form on pol_o[1], gives identical truth tables over all input combinations.
- R12: After reset, all outputs are 0 and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Configuration shift enable; blocks evaluation |
| cfg_d_i | input | 1 | Serial configuration data |
| start_i | input | 1 | Starts an evaluation when idle |
| ded_i | input | 8 | Dedicated inputs |
| bid_i | input | 4 | Input side of the bidirectional pins |
| pol_o | output | 4 | Polarity-selectable outputs |
| xor_o | output | 2 | XOR-combined outputs |
| bid_o | output | 4 | Output data of the bidirectional pins |
| bid_oe_o | output | 4 | Output enables of the bidirectional pins |
| done_o | output | 1 | Evaluation finished |

## Verification
A wrong connection bit, a wrong literal polarity or a wrong gate-to-pin mapping shows up in the first evaluation after configuration, as a truth-table row that disagrees with the programmed function. A fault in the pass count or in the clear-on-start logic changes either the cycle in which done_o rises or the value of a deep path, such as a four-gate chain evaluated with three passes. A fault in input capture shows up when the inputs are scrambled during the run. Feedback between passes is exposed on the bidirectional pins, whose input literal depends on the enable left by the pass before.

// File: rtl/fnand_pkg.sv
package fnand_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} eval_st_e;
endpackage

// File: rtl/fnand_cfg_chain.sv
module fnand_cfg_chain #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= {q_q[W-2:0], d_i};
  end

  assign q_o = q_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_i |=> $stable(q_o)); // R1
endmodule

// File: rtl/fnand_plane.sv
module fnand_plane #(
  parameter int N_LIT   = 24,
  parameter int N_GATES = 24,
  localparam int ROW_W  = N_LIT + N_GATES
) (
  input  logic [N_LIT-1:0]         lit_i,
  input  logic [N_GATES-1:0]       gate_i,
  input  logic [N_GATES*ROW_W-1:0] conn_i,
  output logic [N_GATES-1:0]       gate_o
);
  logic [ROW_W-1:0] src;
  assign src = {gate_i, lit_i};

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    logic [ROW_W-1:0] row;
    assign row = conn_i[g*ROW_W +: ROW_W];
    // unconnected bits act as 1 in the AND; empty row -> NAND = 0
    assign gate_o[g] = ~(&(~row | src));
  end
endmodule

// File: rtl/fnand_out_cells.sv
module fnand_out_cells #(
  parameter int N_GATES = 24,
  parameter int N_POL   = 4,
  parameter int N_XOR   = 2,
  parameter int N_BID   = 4,
  localparam int XOR_BASE = N_POL,
  localparam int BDAT_BASE = XOR_BASE + 2*N_XOR,
  localparam int BOE_BASE = BDAT_BASE + N_BID
) (
  input  logic [N_GATES-1:0]     gate_i,
  input  logic [N_POL+N_BID-1:0] pol_i,
  output logic [N_POL-1:0]       pol_o,
  output logic [N_XOR-1:0]       xor_o,
  output logic [N_BID-1:0]       bid_o,
  output logic [N_BID-1:0]       bid_oe_o
);
  for (genvar k = 0; k < N_POL; k++) begin : g_pol
    assign pol_o[k] = gate_i[k] ^ pol_i[k];
  end
  for (genvar m = 0; m < N_XOR; m++) begin : g_xor
    assign xor_o[m] = gate_i[XOR_BASE+2*m] ^ gate_i[XOR_BASE+2*m+1];
  end
  for (genvar b = 0; b < N_BID; b++) begin : g_bid
    assign bid_o[b]    = gate_i[BDAT_BASE+b] ^ pol_i[N_POL+b];
    assign bid_oe_o[b] = gate_i[BOE_BASE+b];
  end
endmodule

// File: rtl/fnand_fabric.sv
module fnand_fabric #(
  parameter int N_DED   = 8,
  parameter int N_BID   = 4,
  parameter int N_POL   = 4,
  parameter int N_XOR   = 2,
  parameter int N_GATES = 24,
  localparam int N_IN     = N_DED + N_BID,
  localparam int N_LIT    = 2 * N_IN,
  localparam int ROW_W    = N_LIT + N_GATES,
  localparam int POL_BASE = N_GATES * ROW_W,
  localparam int N_PB     = N_POL + N_BID,
  localparam int PASS_W   = $clog2(N_GATES),
  localparam int NP_BASE  = POL_BASE + N_PB,
  localparam int CFG_W    = NP_BASE + PASS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_d_i,
  input  logic             start_i,
  input  logic [N_DED-1:0] ded_i,
  input  logic [N_BID-1:0] bid_i,
  output logic [N_POL-1:0] pol_o,
  output logic [N_XOR-1:0] xor_o,
  output logic [N_BID-1:0] bid_o,
  output logic [N_BID-1:0] bid_oe_o,
  output logic             done_o
);
  import fnand_pkg::*;

  localparam logic [PASS_W:0] MAX_PASS = (PASS_W+1)'(N_GATES);

  logic [CFG_W-1:0]   cfg;
  eval_st_e           state_q;
  logic [PASS_W-1:0]  cnt_q;
  logic               done_q;
  logic [N_GATES-1:0] gate_q, gate_nxt;
  logic [N_DED-1:0]   snap_ded_q;
  logic [N_BID-1:0]   snap_bid_q;
  logic [N_LIT-1:0]   lit;
  logic [PASS_W:0]    npass_raw, npass_eff;

  fnand_cfg_chain #(.W(CFG_W)) i_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(cfg_en_i), .d_i(cfg_d_i), .q_o(cfg)
  );

  assign npass_raw = {1'b0, cfg[NP_BASE +: PASS_W]} + 1'b1;
  assign npass_eff = (npass_raw > MAX_PASS) ? MAX_PASS : npass_raw;

  for (genvar i = 0; i < N_DED; i++) begin : g_ded_lit
    assign lit[2*i]   = snap_ded_q[i];
    assign lit[2*i+1] = ~snap_ded_q[i];
  end
  for (genvar b = 0; b < N_BID; b++) begin : g_bid_lit
    logic v;
    // a driving pin reads back as 0
    assign v = bid_oe_o[b] ? 1'b0 : snap_bid_q[b];
    assign lit[2*(N_DED+b)]   = v;
    assign lit[2*(N_DED+b)+1] = ~v;
  end

  fnand_plane #(.N_LIT(N_LIT), .N_GATES(N_GATES)) i_plane (
    .lit_i (lit), .gate_i(gate_q), .conn_i(cfg[POL_BASE-1:0]), .gate_o(gate_nxt)
  );

  fnand_out_cells #(.N_GATES(N_GATES), .N_POL(N_POL), .N_XOR(N_XOR), .N_BID(N_BID)) i_out (
    .gate_i (gate_q), .pol_i(cfg[POL_BASE +: N_PB]),
    .pol_o  (pol_o), .xor_o(xor_o), .bid_o(bid_o), .bid_oe_o(bid_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      done_q     <= 1'b0;
      gate_q     <= '0;
      snap_ded_q <= '0;
      snap_bid_q <= '0;
    end else if (cfg_en_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          snap_ded_q <= ded_i;
          snap_bid_q <= bid_i;
          gate_q     <= '0;
          cnt_q      <= '0;
          done_q     <= 1'b0;
          state_q    <= ST_RUN;
        end
        ST_RUN: begin
          gate_q <= gate_nxt;
          if ({1'b0, cnt_q} == npass_eff - 1'b1) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;

  AST_CFG_BLOCKS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) cfg_en_i |=> !done_o); // R2
  AST_SNAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q == ST_RUN)) |-> ($stable(snap_ded_q) && $stable(snap_bid_q))); // R3
  AST_DONE_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_RUN)); // R4
  AST_PASS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> ({1'b0, cnt_q} < MAX_PASS)); // R5
  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !cfg_en_i) |=> (gate_q == '0)); // R6
endmodule

// File: tb/test_fnand_fabric.sv
module test_fnand_fabric;
  localparam int NG = 24, ROW = 48, PB = NG*ROW, NPB = PB + 8, CW = NPB + 5;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_d = 0, start = 0;
  logic [7:0] ded = '0;
  logic [3:0] bid = '0;
  logic [3:0] pol_o, bid_o, oe_o;
  logic [1:0] xor_o;
  logic done;
  logic [CW-1:0] cfg;
  int n_cmp = 0, n_bad = 0;

  typedef struct { logic [13:0] val; logic [13:0] msk; string tag; } item_t;
  item_t q[$];

  always #4ns clk = ~clk;

  fnand_fabric i_fnand_fabric (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_d_i(cfg_d), .start_i(start),
    .ded_i(ded), .bid_i(bid), .pol_o(pol_o), .xor_o(xor_o), .bid_o(bid_o),
    .bid_oe_o(oe_o), .done_o(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int tl(int i); return 2*i; endfunction
  function automatic int cl(int i); return 2*i+1; endfunction
  function automatic int fb(int j); return 24+j; endfunction
  task automatic con(int g, int b); cfg[g*ROW+b] = 1'b1; endtask

  task automatic shift_cfg(input bit poke);
    @(negedge clk);
    cfg_en = 1;
    for (int i = CW-1; i >= 0; i--) begin
      cfg_d = cfg[i];
      start = (poke && i == CW/2);
      @(negedge clk);
      if (i == CW-1) check("R2 done drops on cfg_en", 32'(done), 0);
    end
    cfg_en = 0; start = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      check("R2 start ignored during cfg", 32'(done), 0);
    end
  endtask

  task automatic eval(input logic [7:0] d, input logic [3:0] bi, input logic [13:0] ev,
                      input logic [13:0] em, input string tag, input int exp_lat);
    item_t it;
    int lat;
    it.val = ev; it.msk = em; it.tag = tag;
    q.push_back(it);
    ded = d; bid = bi; start = 1;
    @(negedge clk);
    start = 0; ded = ~d; bid = ~bi;   // R3: scramble after capture
    lat = 0;
    while (!done) begin @(negedge clk); lat++; end
    if (exp_lat > 0) check({tag, " latency"}, 32'(lat), 32'(exp_lat));
    @(negedge clk);
  endtask

  // monitor
  initial begin
    logic seen;
    seen = 0;
    forever begin
      @(negedge clk);
      if (done && !seen) begin
        if (q.size() == 0) check("R4 unexpected done", 1, 0);
        else begin
          item_t it;
          logic [13:0] obs;
          it = q.pop_front();
          obs = {oe_o, bid_o, xor_o, pol_o};
          check(it.tag, 32'(obs & it.msk), 32'(it.val & it.msk));
        end
      end
      seen = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic fn(logic a, logic b, logic c); return (a & ~b) | (b & c); endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset outputs", 32'({oe_o, bid_o, xor_o, pol_o, done}), 0);
    rst_n = 1;
    @(negedge clk);

    // program A
    cfg = '0;
    con(0, fb(16)); con(0, fb(17)); con(16, tl(0)); con(16, cl(1)); con(17, tl(1)); con(17, tl(2));
    con(1, fb(18)); con(1, fb(19)); con(18, cl(0)); con(18, cl(1)); con(19, tl(1)); con(19, cl(2));
    cfg[PB+1] = 1;
    con(2, tl(0)); con(2, tl(1)); con(2, tl(2)); cfg[PB+2] = 1;
    con(3, cl(0)); con(3, cl(1));
    con(4, tl(0)); con(5, tl(1));
    con(6, fb(22)); con(20, tl(0)); con(21, fb(20)); con(22, fb(21));
    con(8, tl(9)); con(10, tl(8)); con(12, cl(0));
    cfg[PB+4+3] = 1;
    cfg[NPB +: 5] = 5'd3;
    shift_cfg(0);
    // R1: cfg_d toggling with cfg_en low must not disturb the word
    for (int k = 0; k < 20; k++) begin cfg_d = k[0]; @(negedge clk); end

    for (int v = 0; v < 8; v++) begin
      logic a, b, c, b0, b1, f;
      logic [13:0] e;
      a = v[0]; b = v[1]; c = v[2]; b0 = ~c; b1 = b ^ c; f = fn(a, b, c);
      e = {1'b0, 1'b0, 1'b0, a, 1'b1, (a ? 1'b1 : ~b0), 1'b0, ~b1, a, a ^ b, a | b, a & b & c, f, f};
      eval({5'b0, c, b, a}, {2'b0, b1, b0}, e, 14'h3fff,
           "R11 R6 R7 R8 R9 R10 R3 R1 sop/pos A", (v == 0) ? 4 : 0);
      check("R11 sop equals pos", 32'(pol_o[0]), 32'(pol_o[1]));
    end

    // program B: flipped polarity, 3 passes, start poked during load
    cfg[PB+2] = 0; cfg[PB+3] = 1;
    cfg[NPB +: 5] = 5'd2;
    shift_cfg(1);
    for (int v = 0; v < 8; v++) begin
      logic a, b, c, f;
      logic [13:0] e;
      a = v[0]; b = v[1]; c = v[2]; f = fn(a, b, c);
      e = {12'b0, ~(a | b), ~(a & b & c), f, f} | {8'b0, 1'b1, a ^ b, 4'b0};
      eval({5'b0, c, b, a}, 4'h0, e, 14'h003f, "R7 R8 R6 nand/nor 3 passes B", (v == 0) ? 3 : 0);
    end

    // program C: single pass
    cfg[NPB +: 5] = 5'd0;
    shift_cfg(0);
    for (int v = 0; v < 8; v++) begin
      logic a, b, c, b0, b1;
      logic [13:0] e;
      a = v[0]; b = v[1]; c = v[2]; b0 = b; b1 = ~c;
      e = {3'b0, a, 1'b1, ~b0, 1'b0, ~b1, 1'b1, a ^ b, 1'b0, ~(a & b & c), 1'b0, 1'b1};
      eval({5'b0, c, b, a}, {2'b0, b1, b0}, e, 14'h3ff7, "R6 R9 single pass C", (v == 0) ? 1 : 0);
    end

    // program D: clamp
    cfg[NPB +: 5] = 5'd31;
    shift_cfg(0);
    for (int v = 0; v < 8; v += 3) begin
      logic a, b, c, f;
      logic [13:0] e;
      a = v[0]; b = v[1]; c = v[2]; f = fn(a, b, c);
      e = {8'b0, a, a ^ b, ~(a | b), ~(a & b & c), f, f};
      eval({5'b0, c, b, a}, 4'h0, e, 14'h003f, "R5 clamp D", 24);
    end

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule